// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits between a nonvolatile page controller and the host read path. While the controller runs an internal program or erase cycle, host reads cannot return array contents, so this block substitutes a status byte that lets software detect the end of the cycle. It reports in two ways. The poll bit (bit 7) reads as the inverse of bit 7 of the last byte the host loaded, and it becomes true data again once the cycle ends. The toggle bit (bit 6) changes level on every completed host read for as long as the cycle runs.

The controller drives three inputs: `busy` for the whole internal cycle, `erase_mode` to mark a chip erase, and `last_msb`, which is bit 7 of the most recently loaded byte. The block samples `erase_mode` and `last_msb` on the clock where it first sees `busy` high and holds them until the cycle ends. A chip erase has no meaningful last byte, so only the toggle bit carries status during an erase. The host read strobe `rd_en` is a plain level: high while a read is in progress, and the read counts as complete when the strobe returns low. The block has no flow control. Each read simply sees the byte currently on `rd_data`. When no cycle is running, `rd_data` follows `arr_data` combinationally.

Top module: `wcs_status_reporter`

## Requirements
- R1: After reset, and before `busy` has been seen high, `rd_data` equals `arr_data`.
- R2: When the block is not reporting status, every bit of `rd_data` equals the matching bit of `arr_data`, including changes on `arr_data` within the same cycle.
- R3: Reporting starts at the first rising clock edge at which `busy` is sampled high. It ends at the first rising edge at which `busy` is sampled low. Before that edge, `rd_data` still passes `arr_data`.
- R4: In program mode (`erase_mode` sampled 0 at start), bit 7 of `rd_data` is the inverse of `last_msb` as sampled at start.
- R5: The first status read of each cycle returns bit 6 = 1.
- R6: Each completed read strobe flips bit 6 while reporting with `busy` high. A read is complete at a clock edge where `rd_en` was high at the previous edge and is low now. Bit 6 holds its level between completions and stays steady while the strobe is high.
- R7: While reporting, bits 5 down to 0 of `rd_data` are 0.
- R8: In erase mode (`erase_mode` sampled 1 at start), bit 7 reads 0 and bit 6 toggles as in R6.
- R9: Changes on `last_msb` and `erase_mode` after start have no effect on `rd_data` until the next cycle starts.
- R10: If a read completes on the same edge that starts a cycle, the start wins and bit 6 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy | input | 1 | High while the internal program/erase cycle runs |
| erase_mode | input | 1 | 1 = chip erase, 0 = page program; sampled at start |
| last_msb | input | 1 | Bit 7 of the last byte loaded; sampled at start |
| rd_en | input | 1 | Host read strobe, high during a read |
| arr_data | input | DATA_W | Array read data |
| rd_data | output | DATA_W | Data returned to the host |

## Verification
Two events can land on one clock edge: the start of a new cycle, and the completion of a host read that would advance the toggle bit. The bench provokes this directly by holding the strobe high while idle, then raising `busy` and dropping the strobe together. It judges the outcome by requiring bit 6 to read 1, so the start takes priority over the advance. Random runs also let strobe completions fall on the edges where `busy` rises and falls, and a bench model checks every cycle.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

  typedef enum logic {
    WCS_PROGRAM = 1'b0,
    WCS_ERASE   = 1'b1
  } wcs_mode_e;

  typedef struct packed {
    logic      act;   // status override in force
    wcs_mode_e mode;  // kind of cycle captured at start
    logic      poll;  // inverted msb captured at start
    logic      tog;   // toggle flip-flop
  } wcs_state_t;

endpackage

// File: rtl/wcs_strobe_edge.sv
module wcs_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_en,
  output logic rd_done
);

  logic rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_en;
  end

  // a read finishes when the strobe drops
  assign rd_done = rd_q & ~rd_en;

  AST_DONE_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done); // R6

endmodule

// File: rtl/wcs_cycle_track.sv
module wcs_cycle_track
  import wcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       erase_mode,
  input  logic       last_msb,
  input  logic       rd_done,
  output wcs_state_t st
);

  wcs_state_t st_q, st_d;
  logic       start;

  assign start = busy & ~st_q.act;

  always_comb begin
    st_d     = st_q;
    st_d.act = busy;
    if (start) begin
      // start outranks a read completing on the same edge
      st_d.mode = erase_mode ? WCS_ERASE : WCS_PROGRAM;
      st_d.poll = ~last_msb;
      st_d.tog  = 1'b1;
    end else if (st_q.act && busy && rd_done) begin
      st_d.tog  = ~st_q.tog;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q.act  <= 1'b0;
      st_q.mode <= WCS_PROGRAM;
      st_q.poll <= 1'b0;
      st_q.tog  <= 1'b1;
    end else begin
      st_q <= st_d;
    end
  end

  assign st = st_q;

  AST_FIRST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q.act) |-> st_q.tog); // R5

  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.act && busy && rd_done) |=> (st_q.tog != $past(st_q.tog))); // R6

  AST_TOG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.act && busy && !rd_done) |=> $stable(st_q.tog)); // R6

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.act && $past(st_q.act)) |-> ($stable(st_q.poll) && $stable(st_q.mode))); // R9

endmodule

// File: rtl/wcs_status_mux.sv
module wcs_status_mux
  import wcs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  wcs_state_t        st,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] status_byte;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign status_byte[i] = (st.mode == WCS_ERASE) ? 1'b0 : st.poll;
    end else if (i == TOG_BIT) begin : g_tog
      assign status_byte[i] = st.tog;
    end else begin : g_zero
      assign status_byte[i] = 1'b0;
    end
  end

  assign rd_data = st.act ? status_byte : arr_data;

endmodule

// File: rtl/wcs_status_reporter.sv
module wcs_status_reporter
  import wcs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              erase_mode,
  input  logic              last_msb,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [DATA_W-1:0] ONE_HOT1 = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] LOW_MASK =
    ~((ONE_HOT1 << POLL_BIT) | (ONE_HOT1 << TOG_BIT));

  logic       rd_done;
  wcs_state_t st;

  wcs_strobe_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_done (rd_done)
  );

  wcs_cycle_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .erase_mode (erase_mode),
    .last_msb   (last_msb),
    .rd_done    (rd_done),
    .st         (st)
  );

  wcs_status_mux #(
    .DATA_W   (DATA_W),
    .POLL_BIT (POLL_BIT),
    .TOG_BIT  (TOG_BIT)
  ) u_mux (
    .st       (st),
    .arr_data (arr_data),
    .rd_data  (rd_data)
  );

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(busy) && !st.act) |-> (rd_data == arr_data)); // R2

  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> ((rd_data & LOW_MASK) == '0)); // R7

  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && st.mode == WCS_ERASE) |-> !rd_data[POLL_BIT]); // R8

endmodule

// File: tb/sim_wcs_status_reporter.sv
module sim_wcs_status_reporter;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         busy = 1'b0, erase_mode = 1'b0, last_msb = 1'b0, rd_en = 1'b0;
  logic [W-1:0] arr_data = '0;
  logic [W-1:0] rd_data;

  int  total = 0, bad = 0;
  bit  ended = 1'b0;

  // bench reference state
  bit m_act = 0, m_erase = 0, m_poll = 0, m_tog = 1, m_rdq = 0;

  wcs_status_reporter u0 (
    .clk(clk), .rst_n(rst_n), .busy(busy), .erase_mode(erase_mode),
    .last_msb(last_msb), .rd_en(rd_en), .arr_data(arr_data), .rd_data(rd_data)
  );

  always #2.5 clk = ~clk;

  function automatic logic [W-1:0] expect_byte();
    if (!m_act) return arr_data;
    return {(m_erase ? 1'b0 : m_poll), m_tog, 6'b0};
  endfunction

  function automatic string req_of();
    if (!m_act) return "R2";
    return m_erase ? "R8" : "R4/R6/R7";
  endfunction

  task automatic check(input logic [W-1:0] exp, input string req);
    total++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL %s: rd_data=%h expected=%h at %0t", req, rd_data, exp, $time);
    end
  endtask

  // advance one edge, updating the reference model with pre-edge inputs
  task automatic tick();
    bit start, done;
    start = busy && !m_act;
    done  = m_rdq && !rd_en;
    if (start) begin
      m_erase = erase_mode; m_poll = ~last_msb; m_tog = 1;
    end else if (m_act && busy && done) m_tog = ~m_tog;
    m_act = busy; m_rdq = rd_en;
    @(posedge clk); #1;
  endtask

  task automatic read_pulse();
    rd_en = 1; tick(); rd_en = 0; tick();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!ended) begin
      ended = 1; total++; bad++;
      $display("FAIL watchdog: expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    arr_data = 8'h3c;
    repeat (3) @(posedge clk);
    #1;
    check(8'h3c, "R1");
    rst_n = 1;
    tick();
    arr_data = 8'hc5; #1;
    check(8'hc5, "R1");

    // R3: busy raised, not yet sampled -> still array data
    last_msb = 1; erase_mode = 0; busy = 1; #1;
    check(arr_data, "R3");
    tick();
    check({1'b0, 1'b1, 6'b0}, "R3/R4/R5");
    // R9: later changes to captured inputs ignored
    last_msb = 0; erase_mode = 1; arr_data = 8'hff; tick();
    check({1'b0, 1'b1, 6'b0}, "R9");
    // R6: strobe high holds, completion flips
    rd_en = 1; tick(); check(8'h40, "R6");
    rd_en = 0; tick(); check(8'h00, "R6");
    read_pulse(); check(8'h40, "R6");
    // R3: end of cycle, lag of one edge
    busy = 0; #1; check(8'h40, "R3");
    tick(); check(arr_data, "R3");

    // R8: erase cycle
    erase_mode = 1; last_msb = 0; busy = 1; tick();
    check(8'h40, "R8");
    read_pulse(); check(8'h00, "R8");
    busy = 0; tick(); check(arr_data, "R2");

    // R10: read completion coincides with start
    erase_mode = 0; last_msb = 0; rd_en = 1; tick();
    busy = 1; rd_en = 0; tick();
    check(8'hc0, "R10");
    busy = 0; tick();

    // random mix against reference model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 9) == 0) busy = ~busy;
      if ($urandom_range(0, 2) == 0) rd_en = ~rd_en;
      erase_mode = 1'($urandom);
      last_msb   = 1'($urandom);
      arr_data   = 8'($urandom);
      tick();
      check(expect_byte(), req_of());
    end

    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule